// File: doc/BRIEF.md
# Address Generation ALU with Modifier-Selected Arithmetic

This block computes data memory addresses for a signal-processing datapath. It holds a small file of pointer triplets. Each triplet has a pointer, a step register and a mode register. In any clock cycle one triplet can be used to form an effective address and, optionally, to advance its pointer. The mode register of the chosen triplet sets the arithmetic used:

- plain two's-complement stepping;
- a circular buffer of arbitrary length;
- free wrapping of a power-of-two block of low bits;
- bit-reversed (carry from the top bit down) stepping for FFT data reordering.

Three adders work side by side on each update, and one of their results is selected:

- a straight adder;
- a correction adder that folds an overshooting circular pointer back into its buffer;
- a reverse-carry adder.

This lets circular and bit-reversed addressing complete in one cycle. A load port writes any register of any triplet. A registered read port returns a whole triplet. Memory access and instruction decoding live elsewhere.

Top module: `agu_core`

## Requirements
- R1: After synchronous reset:
  - every pointer and every step register is 0;
  - every mode register is 0xFFFFFF;
  - `ea_o`, `ea_valid_o` and the three read outputs are 0.
- R2: With `ld_en` high, `ld_sel` selects the register of triplet `ld_idx` that takes `ld_data`: 0 = pointer, 1 = step, 2 = mode, 3 = nothing. A pointer load (`ld_sel`=0) in the same cycle as a post-update cancels that update's pointer write-back, whichever triplet the update names. The effective address is still produced.
- R3: The read outputs show the triplet named by `rd_idx` one cycle later, as it stood before that clock edge.
- R4: Mode register 0xFFFFFF, or any code not listed in R5 to R7, gives linear arithmetic: pointer plus or minus step, modulo 2^24.
- R5: Mode register M in 1..0x7FFF gives a circular buffer of length M+1.
  - The buffer starts at the pointer with its low k bits cleared, where 2^k is the smallest power of two not below M+1.
  - A pointer inside the buffer, moved by a step no larger than M+1, stays inside it. It wraps by adding or subtracting M+1.
- R6: Mode register 0x8000 | (2^k − 1), for k from 1 to 15, gives multi-wrap arithmetic:
  - the low k bits take the low k bits of the linear result;
  - the upper bits stay unchanged.
- R7: Mode register 0 gives reverse-carry arithmetic. Pointer and step are added (or subtracted) with carries and borrows propagating from bit 23 toward bit 0.
- R8: `upd_kind` picks the operation on triplet `upd_idx`:
  - 1 = post-increment by 1;
  - 2 = post-decrement by 1;
  - 3 = post-add step;
  - 4 = post-subtract step;
  - 5 = indexed;
  - 0, 6 and 7 = no operation.

  Post kinds output the old pointer as the effective address and write back the new pointer. Indexed outputs the mode-dependent pointer-plus-step result and writes nothing back. At most one pointer changes per cycle.
- R9: `ea_valid_o` is 1 in the cycle after `upd_kind` was 1..5 and 0 otherwise. `ea_o` changes only in those cycles and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Register load strobe |
| ld_sel | input | 2 | Load target: 0 pointer, 1 step, 2 mode, 3 none |
| ld_idx | input | 2 | Triplet written by a load |
| ld_data | input | 24 | Load value |
| upd_kind | input | 3 | Operation code (see R8) |
| upd_idx | input | 2 | Triplet used by the operation |
| rd_idx | input | 2 | Triplet shown on the read port |
| rd_addr_o | output | 24 | Registered pointer of the read triplet |
| rd_off_o | output | 24 | Registered step of the read triplet |
| rd_mod_o | output | 24 | Registered mode register of the read triplet |
| ea_o | output | 24 | Registered effective address |
| ea_valid_o | output | 1 | Effective address produced in the previous cycle |

## Verification
The assertions watch every cycle for the following:
- A circular pointer inside its buffer never leaves it.
- Multi-wrap updates never disturb the upper bits.
- Linear increments step by exactly one.
- Post operations return the old pointer.
- Indexed operations leave the pointer untouched.
- The valid flag tracks the operation code.

Only the bench's scenarios can show the following:
- that exact wrap values match a buffer length that is not a power of two;
- that reverse-carry sequences come out in bit-reversed order;
- that a pointer load beats a concurrent write-back;
- that the read port returns the right triplet after a chain of mixed loads and updates.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    MODE_LIN   = 2'd0,
    MODE_MOD   = 2'd1,
    MODE_MWRAP = 2'd2,
    MODE_REV   = 2'd3
  } mode_e;

  localparam logic [2:0] K_NONE = 3'd0;
  localparam logic [2:0] K_INC  = 3'd1;
  localparam logic [2:0] K_DEC  = 3'd2;
  localparam logic [2:0] K_ADD  = 3'd3;
  localparam logic [2:0] K_SUB  = 3'd4;
  localparam logic [2:0] K_IDX  = 3'd5;

  localparam logic [1:0] SEL_PTR  = 2'd0;
  localparam logic [1:0] SEL_STEP = 2'd1;
  localparam logic [1:0] SEL_MODE = 2'd2;
endpackage

// File: rtl/agu_trip_rf.sv
module agu_trip_rf #(
  parameter int AW    = 24,
  parameter int NTRIP = 4,
  localparam int IW   = $clog2(NTRIP)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ptr_we,
  input  logic [IW-1:0] ptr_widx,
  input  logic [AW-1:0] ptr_wdata,
  input  logic          step_we,
  input  logic          mode_we,
  input  logic [IW-1:0] cfg_widx,
  input  logic [AW-1:0] cfg_wdata,
  input  logic [IW-1:0] ra_idx,
  output logic [AW-1:0] ra_ptr,
  output logic [AW-1:0] ra_step,
  output logic [AW-1:0] ra_mode,
  input  logic [IW-1:0] rb_idx,
  output logic [AW-1:0] rb_ptr,
  output logic [AW-1:0] rb_step,
  output logic [AW-1:0] rb_mode
);
  logic [AW-1:0] ptr_q  [NTRIP];
  logic [AW-1:0] step_q [NTRIP];
  logic [AW-1:0] mode_q [NTRIP];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NTRIP; i++) begin
        ptr_q[i]  <= '0;
        step_q[i] <= '0;
        mode_q[i] <= '1;
      end
    end else begin
      if (ptr_we)  ptr_q[ptr_widx]  <= ptr_wdata;
      if (step_we) step_q[cfg_widx] <= cfg_wdata;
      if (mode_we) mode_q[cfg_widx] <= cfg_wdata;
    end
  end

  assign ra_ptr  = ptr_q[ra_idx];
  assign ra_step = step_q[ra_idx];
  assign ra_mode = mode_q[ra_idx];
  assign rb_ptr  = ptr_q[rb_idx];
  assign rb_step = step_q[rb_idx];
  assign rb_mode = mode_q[rb_idx];
endmodule

// File: rtl/agu_mdecode.sv
module agu_mdecode
  import agu_pkg::*;
#(
  parameter int AW = 24,
  parameter int MW = 15
) (
  input  logic [AW-1:0] modreg,
  output mode_e         mode,
  output logic [AW-1:0] mask,
  output logic [AW:0]   span
);
  localparam logic [AW-MW-1:0] HI_MWRAP = 1;

  logic [MW-1:0]    low;
  logic [AW-MW-1:0] hi;
  logic [MW-1:0]    smear;
  logic             pow2m1;
  logic             acc;

  assign low    = modreg[MW-1:0];
  assign hi     = modreg[AW-1:MW];
  assign pow2m1 = (low != '0) && ((low & (low + 1'b1)) == '0);
  assign span   = {1'b0, modreg} + 1'b1;

  always_comb begin
    acc = 1'b0;
    for (int i = MW - 1; i >= 0; i--) begin
      acc      = acc | low[i];
      smear[i] = acc;
    end
  end

  always_comb begin
    mode = MODE_LIN;
    mask = '0;
    if (&modreg) begin
      mode = MODE_LIN;
    end else if (modreg == '0) begin
      mode = MODE_REV;
    end else if (hi == '0) begin
      mode = MODE_MOD;
      mask = {{(AW-MW){1'b0}}, smear};
    end else if (hi == HI_MWRAP && pow2m1) begin
      mode = MODE_MWRAP;
      mask = {{(AW-MW){1'b0}}, low};
    end
  end
endmodule

// File: rtl/agu_arith.sv
module agu_arith
  import agu_pkg::*;
#(
  parameter int AW = 24
) (
  input  mode_e         mode,
  input  logic [AW-1:0] mask,
  input  logic [AW:0]   span,
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] mag,
  input  logic          sub,
  output logic [AW-1:0] res
);
  logic [AW-1:0] lin_sum, mod_sum, mw_sum, rev_sum;
  logic [AW-1:0] ptr_r, mag_r, sum_r;
  logic [AW-1:0] rel;
  logic          over, under;

  // offset adder
  assign lin_sum = sub ? ptr - mag : ptr + mag;

  // modulo correction adder
  assign rel   = ptr & mask;
  assign over  = ({1'b0, rel} + {1'b0, mag}) >= span;
  assign under = rel < mag;
  always_comb begin
    mod_sum = lin_sum;
    if (sub && under)       mod_sum = lin_sum + span[AW-1:0];
    else if (!sub && over)  mod_sum = lin_sum - span[AW-1:0];
  end

  assign mw_sum = (ptr & ~mask) | (lin_sum & mask);

  // reverse-carry adder: same operands, carry runs toward bit 0
  for (genvar g = 0; g < AW; g++) begin : g_rev
    assign ptr_r[g]   = ptr[AW-1-g];
    assign mag_r[g]   = mag[AW-1-g];
    assign rev_sum[g] = sum_r[AW-1-g];
  end
  assign sum_r = sub ? ptr_r - mag_r : ptr_r + mag_r;

  always_comb begin
    unique case (mode)
      MODE_MOD:   res = mod_sum;
      MODE_MWRAP: res = mw_sum;
      MODE_REV:   res = rev_sum;
      default:    res = lin_sum;
    endcase
  end
endmodule

// File: rtl/agu_core.sv
module agu_core
  import agu_pkg::*;
#(
  parameter int AW    = 24,
  parameter int NTRIP = 4,
  parameter int MODW  = 15,
  localparam int IW   = $clog2(NTRIP)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_en,
  input  logic [1:0]    ld_sel,
  input  logic [IW-1:0] ld_idx,
  input  logic [AW-1:0] ld_data,
  input  logic [2:0]    upd_kind,
  input  logic [IW-1:0] upd_idx,
  input  logic [IW-1:0] rd_idx,
  output logic [AW-1:0] rd_addr_o,
  output logic [AW-1:0] rd_off_o,
  output logic [AW-1:0] rd_mod_o,
  output logic [AW-1:0] ea_o,
  output logic          ea_valid_o
);
  logic [AW-1:0] cur_a, cur_o, cur_m;
  logic [AW-1:0] rb_a, rb_o, rb_m;
  logic [AW-1:0] next_a, mag, mask;
  logic [AW:0]   span;
  mode_e         mode;
  logic          is_post, is_idx, step_sub, ld_ptr;

  assign is_post  = (upd_kind == K_INC) || (upd_kind == K_DEC) ||
                    (upd_kind == K_ADD) || (upd_kind == K_SUB);
  assign is_idx   = (upd_kind == K_IDX);
  assign step_sub = (upd_kind == K_DEC) || (upd_kind == K_SUB);
  assign mag      = ((upd_kind == K_INC) || (upd_kind == K_DEC)) ? AW'(1) : cur_o;
  assign ld_ptr   = ld_en && (ld_sel == SEL_PTR);

  agu_trip_rf #(.AW(AW), .NTRIP(NTRIP)) u_rf (
    .clk       (clk),
    .rst       (rst),
    .ptr_we    (ld_ptr || is_post),
    .ptr_widx  (ld_ptr ? ld_idx : upd_idx),
    .ptr_wdata (ld_ptr ? ld_data : next_a),
    .step_we   (ld_en && (ld_sel == SEL_STEP)),
    .mode_we   (ld_en && (ld_sel == SEL_MODE)),
    .cfg_widx  (ld_idx),
    .cfg_wdata (ld_data),
    .ra_idx    (upd_idx),
    .ra_ptr    (cur_a),
    .ra_step   (cur_o),
    .ra_mode   (cur_m),
    .rb_idx    (rd_idx),
    .rb_ptr    (rb_a),
    .rb_step   (rb_o),
    .rb_mode   (rb_m)
  );

  agu_mdecode #(.AW(AW), .MW(MODW)) u_dec (
    .modreg (cur_m),
    .mode   (mode),
    .mask   (mask),
    .span   (span)
  );

  agu_arith #(.AW(AW)) u_alu (
    .mode (mode),
    .mask (mask),
    .span (span),
    .ptr  (cur_a),
    .mag  (mag),
    .sub  (step_sub),
    .res  (next_a)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ea_o       <= '0;
      ea_valid_o <= 1'b0;
      rd_addr_o  <= '0;
      rd_off_o   <= '0;
      rd_mod_o   <= '0;
    end else begin
      ea_valid_o <= is_post || is_idx;
      if (is_post)     ea_o <= cur_a;
      else if (is_idx) ea_o <= next_a;
      rd_addr_o <= rb_a;
      rd_off_o  <= rb_o;
      rd_mod_o  <= rb_m;
    end
  end
endmodule

// File: rtl/agu_core_chk.sv
module agu_core_chk
  import agu_pkg::*;
#(
  parameter int AW = 24,
  parameter int IW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    upd_kind,
  input logic [IW-1:0] upd_idx,
  input logic          ld_en,
  input logic [1:0]    ld_sel,
  input logic [AW-1:0] ea_o,
  input logic          ea_valid_o,
  input logic [AW-1:0] cur_a,
  input logic [AW-1:0] next_a,
  input logic [AW-1:0] mag,
  input logic [AW-1:0] mask,
  input logic [AW:0]   span,
  input mode_e         mode
);
  logic op_live, op_post;
  assign op_live = (upd_kind >= K_INC) && (upd_kind <= K_IDX);
  assign op_post = (upd_kind >= K_INC) && (upd_kind <= K_SUB);

  AST_LIN_INC: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_LIN && upd_kind == K_INC) |-> next_a == cur_a + 1'b1); // R4

  AST_MOD_STAYS_IN_BUF: assert property (@(posedge clk) disable iff (rst)
    (op_live && mode == MODE_MOD && ({1'b0, cur_a & mask} < span) && ({1'b0, mag} <= span))
      |-> (((next_a & ~mask) == (cur_a & ~mask)) && ({1'b0, next_a & mask} < span))); // R5

  AST_MWRAP_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
    (op_live && mode == MODE_MWRAP) |-> (next_a & ~mask) == (cur_a & ~mask)); // R6

  AST_POST_EA_OLD: assert property (@(posedge clk) disable iff (rst)
    op_post |=> ea_o == $past(cur_a)); // R8

  AST_IDX_NO_WRITEBACK: assert property (@(posedge clk) disable iff (rst)
    (upd_kind == K_IDX && !(ld_en && ld_sel == SEL_PTR)) ##1 (upd_idx == $past(upd_idx))
      |-> cur_a == $past(cur_a)); // R8

  AST_VALID_SET: assert property (@(posedge clk) disable iff (rst)
    op_live |=> ea_valid_o); // R9

  AST_VALID_CLR: assert property (@(posedge clk) disable iff (rst)
    !op_live |=> (!ea_valid_o && $stable(ea_o))); // R9
endmodule

bind agu_core agu_core_chk #(.AW(AW), .IW(IW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .upd_kind   (upd_kind),
  .upd_idx    (upd_idx),
  .ld_en      (ld_en),
  .ld_sel     (ld_sel),
  .ea_o       (ea_o),
  .ea_valid_o (ea_valid_o),
  .cur_a      (cur_a),
  .next_a     (next_a),
  .mag        (mag),
  .mask       (mask),
  .span       (span),
  .mode       (mode)
);

// File: tb/test_agu_core.sv
module test_agu_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_en = 1'b0;
  logic [1:0]  ld_sel = 2'd3;
  logic [1:0]  ld_idx = '0;
  logic [23:0] ld_data = '0;
  logic [2:0]  upd_kind = '0;
  logic [1:0]  upd_idx = '0;
  logic [1:0]  rd_idx = '0;
  logic [23:0] rd_addr_o, rd_off_o, rd_mod_o, ea_o;
  logic        ea_valid_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [23:0] m_ptr [4];
  logic [23:0] m_stp [4];
  logic [23:0] m_mod [4];

  always #4 clk = ~clk;

  agu_core i_agu_core (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_sel(ld_sel), .ld_idx(ld_idx),
    .ld_data(ld_data), .upd_kind(upd_kind), .upd_idx(upd_idx), .rd_idx(rd_idx),
    .rd_addr_o(rd_addr_o), .rd_off_o(rd_off_o), .rd_mod_o(rd_mod_o),
    .ea_o(ea_o), .ea_valid_o(ea_valid_o)
  );

  // 0 linear, 1 circular, 2 multi-wrap, 3 reverse-carry
  function automatic int ref_mode(logic [23:0] m);
    if (m == 24'hFFFFFF) return 0;
    if (m == 24'h0) return 3;
    if (m <= 24'h7FFF) return 1;
    for (int k = 1; k <= 15; k++)
      if (m == (24'h8000 | ((24'h1 << k) - 24'h1))) return 2;
    return 0;
  endfunction

  function automatic logic [23:0] ref_step(logic [23:0] a, logic [23:0] m,
                                           logic [23:0] d, bit neg);
    longint p, base, rel, s, nr;
    logic [23:0] r;
    bit c;
    case (ref_mode(m))
      1: begin
        p = 1;
        while (p < longint'(m) + 1) p = p * 2;
        rel = longint'(a) % p; base = longint'(a) - rel; s = longint'(m) + 1;
        nr = neg ? rel - longint'(d) : rel + longint'(d);
        nr = ((nr % s) + s) % s;
        return 24'(base + nr);
      end
      2: begin
        p = longint'(m[14:0]) + 1;
        rel = longint'(a) % p; base = longint'(a) - rel;
        nr = neg ? rel - longint'(d) : rel + longint'(d);
        nr = ((nr % p) + p) % p;
        return 24'(base + nr);
      end
      3: begin
        c = neg;
        for (int i = 23; i >= 0; i--) begin
          r[i] = a[i] ^ (d[i] ^ neg) ^ c;
          c = (a[i] & (d[i] ^ neg)) | (c & (a[i] ^ d[i] ^ neg));
        end
        return r;
      end
      default: return neg ? a - d : a + d;
    endcase
  endfunction

  task automatic chk(string req, string what, logic [23:0] act, logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One cycle of stimulus, then compare outputs at the following falling edge.
  task automatic step(bit le, logic [1:0] ls, int li, logic [23:0] ldv,
                      logic [2:0] k, int ui, int ri, string req);
    logic [23:0] e_a, e_o, e_m, e_ea, nxt;
    bit post, idx, wb_ok;
    e_a = m_ptr[ri]; e_o = m_stp[ri]; e_m = m_mod[ri];
    post = (k >= 3'd1 && k <= 3'd4);
    idx = (k == 3'd5);
    e_ea = ea_o;
    if (post) begin
      e_ea = m_ptr[ui];
      nxt = ref_step(m_ptr[ui], m_mod[ui],
                     (k == 3'd1 || k == 3'd2) ? 24'd1 : m_stp[ui], (k == 3'd2 || k == 3'd4));
    end else begin
      nxt = m_ptr[ui];
    end
    if (idx) e_ea = ref_step(m_ptr[ui], m_mod[ui], m_stp[ui], 1'b0);
    wb_ok = !(le && ls == 2'd0);
    if (post && wb_ok) m_ptr[ui] = nxt;
    if (le) begin
      if (ls == 2'd0) m_ptr[li] = ldv;
      if (ls == 2'd1) m_stp[li] = ldv;
      if (ls == 2'd2) m_mod[li] = ldv;
    end
    ld_en = le; ld_sel = ls; ld_idx = 2'(li); ld_data = ldv;
    upd_kind = k; upd_idx = 2'(ui); rd_idx = 2'(ri);
    @(posedge clk);
    @(negedge clk);
    chk("R9", "ea_valid", {23'd0, ea_valid_o}, {23'd0, (post || idx)});
    chk(req, "ea", ea_o, e_ea);
    chk("R3", "rd_addr", rd_addr_o, e_a);
    chk("R3", "rd_off", rd_off_o, e_o);
    chk("R3", "rd_mod", rd_mod_o, e_m);
    ld_en = 1'b0; upd_kind = 3'd0;
  endtask

  task automatic load(int i, logic [1:0] s, logic [23:0] v);
    step(1'b1, s, i, v, 3'd0, 0, i, "R2");
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [23:0] mv, av, ov;
    int r0, kk, ui;
    logic [2:0] kind;
    bit ok;
    longint p;
    void'($urandom(32'd12345));
    for (int i = 0; i < 4; i++) begin
      m_ptr[i] = '0; m_stp[i] = '0; m_mod[i] = 24'hFFFFFF;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset values
    chk("R1", "ea", ea_o, 24'd0);
    chk("R1", "ea_valid", {23'd0, ea_valid_o}, 24'd0);
    chk("R1", "rd_addr", rd_addr_o, 24'd0);
    step(1'b0, 2'd3, 0, 0, 3'd0, 0, 2, "R1");
    chk("R1", "rd_mod reset", rd_mod_o, 24'hFFFFFF);

    // R4 linear: wrap at the top of the space
    load(0, 2'd0, 24'hFFFFFF);
    step(1'b0, 2'd3, 0, 0, 3'd1, 0, 0, "R4");
    step(1'b0, 2'd3, 0, 0, 3'd2, 0, 0, "R4");
    // R4 unsupported code behaves linear
    load(0, 2'd2, 24'h008005 | 24'h008000);
    load(0, 2'd1, 24'd7);
    step(1'b0, 2'd3, 0, 0, 3'd3, 0, 0, "R4");
    // R5 circular length 10 at base 0x40
    load(1, 2'd2, 24'd9);
    load(1, 2'd0, 24'h49);
    load(1, 2'd1, 24'd10);
    step(1'b0, 2'd3, 0, 0, 3'd1, 1, 1, "R5");
    step(1'b0, 2'd3, 0, 0, 3'd2, 1, 1, "R5");
    step(1'b0, 2'd3, 0, 0, 3'd3, 1, 1, "R5");
    step(1'b0, 2'd3, 0, 0, 3'd4, 1, 1, "R5");
    step(1'b0, 2'd3, 0, 0, 3'd5, 1, 1, "R5");
    chk("R5", "wrapped ptr", m_ptr[1], 24'h49);
    // R6 multi-wrap 16
    load(2, 2'd2, 24'h00800F);
    load(2, 2'd0, 24'h12345E);
    load(2, 2'd1, 24'd5);
    step(1'b0, 2'd3, 0, 0, 3'd3, 2, 2, "R6");
    step(1'b0, 2'd3, 0, 0, 3'd4, 2, 2, "R6");
    step(1'b0, 2'd3, 0, 0, 3'd4, 2, 2, "R6");
    // R7 reverse carry, 8-point sequence
    load(3, 2'd2, 24'd0);
    load(3, 2'd1, 24'h000004);
    for (int i = 0; i < 9; i++) step(1'b0, 2'd3, 0, 0, 3'd3, 3, 3, "R7");
    step(1'b0, 2'd3, 0, 0, 3'd4, 3, 3, "R7");
    // R2 pointer load cancels concurrent write-back of another triplet
    step(1'b1, 2'd0, 0, 24'hABCDEF, 3'd1, 2, 2, "R2");
    step(1'b0, 2'd3, 0, 0, 3'd0, 0, 2, "R2");
    step(1'b0, 2'd3, 0, 0, 3'd0, 0, 0, "R2");
    // R2 ld_sel 3 writes nothing; R8 kinds 0/6/7 do nothing
    step(1'b1, 2'd3, 1, 24'h555555, 3'd6, 1, 1, "R2");
    step(1'b0, 2'd3, 0, 0, 3'd7, 1, 1, "R8");
    step(1'b0, 2'd3, 0, 0, 3'd0, 0, 1, "R8");

    // R8 constrained random mix
    for (int n = 0; n < 4000; n++) begin
      r0 = int'($urandom_range(0, 9));
      if (r0 < 2) begin
        kk = int'($urandom_range(0, 4));
        if (kk == 0) mv = 24'hFFFFFF;
        else if (kk == 1) mv = 24'd0;
        else if (kk == 2) mv = 24'($urandom_range(1, 300));
        else if (kk == 3) mv = 24'($urandom_range(1, 24'h7FFF));
        else mv = 24'h8000 | ((24'h1 << $urandom_range(1, 15)) - 24'h1);
        load(int'($urandom_range(0, 3)), 2'd2, mv);
      end else if (r0 < 3) begin
        av = 24'($urandom);
        load(int'($urandom_range(0, 3)), 2'd0, av);
      end else if (r0 < 4) begin
        ov = ($urandom_range(0, 1) == 1) ? 24'($urandom_range(0, 64)) : 24'($urandom);
        load(int'($urandom_range(0, 3)), 2'd1, ov);
      end else begin
        ui = int'($urandom_range(0, 3));
        kind = 3'($urandom_range(0, 7));
        if (ref_mode(m_mod[ui]) == 1) begin
          p = 1;
          while (p < longint'(m_mod[ui]) + 1) p = p * 2;
          ok = (longint'(m_ptr[ui]) % p) <= longint'(m_mod[ui]);
          if (kind >= 3'd3 && kind <= 3'd5)
            ok = ok && (m_stp[ui] <= m_mod[ui] + 24'd1);
          if (!ok) kind = 3'd0;
        end
        step(1'b0, 2'd3, 0, 0, kind, ui, int'($urandom_range(0, 3)), "R8");
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule